// File: doc/BRIEF.md
# Transmit Packet Scheduler for a PCIe Transaction Layer

This block sits between a set of outbound packet sources and a 256-bit streaming transmit port of a PCIe transaction layer. Each source presents the head of its own queue: a 32-byte header with a small descriptor (packet kind, length in dwords, tag, requester ID), followed by a separate stream of payload beats. The sources are a memory request builder (writes and reads), an interrupt message writer, and two register/burst responders that return read completions.

Each cycle with no packet in flight, the scheduler decides which source heads the link can take. A posted packet needs posted header and data credit. A completion needs completion header and data credit. A read needs non-posted header credit and room in the read-reorder buffer. If a posted packet cannot go, no read and no completion may overtake it. A blocked read or completion does not hold back the others. Among the sources that may go, a round-robin choice picks one. The block then reports the credit it spends and emits the packet: the header in the first beat, then the payload beats.

When the last beat of a memory write is taken, the block sends a local dummy completion with that write's tag and requester ID. Agents use it to know that their data has left.

Top module: `tx_sched`

## Requirements
- R1: A posted packet (kind 0 = memory write, kind 3 = interrupt message) is granted only when posted header credit is at least 1 and posted data credit is at least ceil(len/4). A completion (kind 2) needs completion header credit of at least 1 and completion data credit of at least ceil(len/4). A grant drives `spend_valid` for one cycle, with the source index, the kind and ceil(len/4) in `spend_dunits`.
- R2: A memory read (kind 1) is granted only when non-posted header credit is at least 1 and `rob_free` is at least ceil(len/4).
- R3: While any source head is a posted packet that lacks credit, no read or completion is granted. A read or completion that lacks credit or room does not stop other sources.
- R4: Among the sources that may go, the grant goes to the first one after the most recently granted index, in ascending index order with wrap-around.
- R5: The first beat of a packet carries the 256-bit header in bits [255:0] with `tx_sop` high. A data-carrying packet then sends ceil(len/8) payload beats, taken in order from its source. A read is a single beat. `tx_last` marks the final beat.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sop` and `tx_last` stay unchanged in the next cycle.
- R7: One cycle after the final beat of a memory write is accepted, `dc_valid` pulses for one cycle with that write's tag and requester ID. No other kind produces a pulse.
- R8: During reset, `tx_valid`, `spend_valid` and `dc_valid` are low. After reset, source 0 has first priority.
- R9: A granted packet is sent in full, with no beat of another packet between its first and last beat. No new grant is made until its last beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_hdr_valid | input | NSRC | Source head header present |
| src_hdr | input | NSRC x 256 | Header of each source head |
| src_kind | input | NSRC x 2 | Packet kind: 0 write, 1 read, 2 completion, 3 interrupt message |
| src_len | input | NSRC x LEN_W | Length in dwords |
| src_tag | input | NSRC x TAG_W | Tag of the head packet |
| src_rid | input | NSRC x RID_W | Requester ID of the head packet |
| src_hdr_ready | output | NSRC | Header taken from a source |
| src_pl_valid | input | NSRC | Payload beat present |
| src_pl_data | input | NSRC x DATA_W | Payload beat |
| src_pl_ready | output | NSRC | Payload beat taken |
| cr_ph | input | CR_W | Posted header credit available |
| cr_pd | input | CR_W | Posted data credit available (4-dword units) |
| cr_nph | input | CR_W | Non-posted header credit available |
| cr_cplh | input | CR_W | Completion header credit available |
| cr_cpld | input | CR_W | Completion data credit available |
| rob_free | input | ROB_W | Free read-reorder buffer space (4-dword units) |
| spend_valid | output | 1 | A packet was granted this cycle |
| spend_src | output | SRC_W | Granted source |
| spend_kind | output | 2 | Granted packet kind |
| spend_dunits | output | CR_W | Data or reorder units of the grant |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_data | output | DATA_W | Transmit beat |
| tx_sop | output | 1 | First beat of a packet |
| tx_last | output | 1 | Final beat of a packet |
| dc_valid | output | 1 | Dummy completion for a finished write |
| dc_tag | output | TAG_W | Tag of the finished write |
| dc_rid | output | RID_W | Requester ID of the finished write |

## Verification
The bench builds the block with its default parameters: four sources, a 256-bit bus that carries eight payload dwords per beat, 10-bit lengths and 12-bit credit counters. With these values, small credit levels of 0 to 3 units reach the exact-fit boundary of the credit check. Writes of 9 and 17 dwords hit partial last beats. A zero-length completion gives a header-only packet. Four sources are enough for the round-robin to wrap and skip idle sources. A behavioural model in the bench predicts every grant, every beat and every dummy completion, and compares them each cycle while the sink's ready and the sources' payload arrival stall at random.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;

   typedef enum logic [1:0] {
      TK_MWR = 2'd0,
      TK_MRD = 2'd1,
      TK_CPL = 2'd2,
      TK_MSI = 2'd3
   } tlp_kind_e;

   localparam int HDR_W = 256;

   function automatic logic kind_posted(input tlp_kind_e k);
      return (k == TK_MWR) || (k == TK_MSI);
   endfunction

   function automatic logic kind_carries_data(input tlp_kind_e k);
      return k != TK_MRD;
   endfunction

endpackage

// File: rtl/tx_sched_elig.sv
module tx_sched_elig
   import tx_sched_pkg::*;
#(
   parameter int LEN_W = 10,
   parameter int CR_W  = 12,
   parameter int ROB_W = 10
) (
   input  logic             head_valid,
   input  tlp_kind_e        kind,
   input  logic [LEN_W-1:0] len,
   input  logic [CR_W-1:0]  cr_ph,
   input  logic [CR_W-1:0]  cr_pd,
   input  logic [CR_W-1:0]  cr_nph,
   input  logic [CR_W-1:0]  cr_cplh,
   input  logic [CR_W-1:0]  cr_cpld,
   input  logic [ROB_W-1:0] rob_free,
   output logic             fits,
   output logic             posted_blocked,
   output logic [CR_W-1:0]  dunits
);
   localparam int CW = (CR_W > ROB_W) ? CR_W : ROB_W;

   if (CR_W < LEN_W - 1) begin : g_bad_cr
      $error("tx_sched_elig: CR_W too narrow for LEN_W");
   end
   if (ROB_W < LEN_W - 1) begin : g_bad_rob
      $error("tx_sched_elig: ROB_W too narrow for LEN_W");
   end

   logic [LEN_W:0] len_rnd;
   logic [CW-1:0]  du_c, pd_c, cpld_c, rob_c;
   logic           room;

   assign len_rnd = {1'b0, len} + (LEN_W+1)'(3);
   assign du_c    = CW'(len_rnd[LEN_W:2]);
   assign pd_c    = CW'(cr_pd);
   assign cpld_c  = CW'(cr_cpld);
   assign rob_c   = CW'(rob_free);
   assign dunits  = CR_W'(len_rnd[LEN_W:2]);

   always_comb begin
      unique case (kind)
         TK_MWR, TK_MSI: room = (cr_ph != '0) && (pd_c >= du_c);
         TK_MRD:         room = (cr_nph != '0) && (rob_c >= du_c);
         default:        room = (cr_cplh != '0) && (cpld_c >= du_c);
      endcase
      fits           = head_valid && room;
      posted_blocked = head_valid && kind_posted(kind) && !room;
   end

endmodule

// File: rtl/tx_sched_rr.sv
module tx_sched_rr #(
   parameter int N = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [N-1:0]                     req,
   input  logic                             adv,
   output logic                             any,
   output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx
);
   localparam int W = (N > 1) ? $clog2(N) : 1;

   logic [W-1:0] last_q;
   logic         others;

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int k = 1; k <= N; k++) begin
         int j;
         j = int'(last_q) + k;
         if (j >= N) j = j - N;
         if (!any && req[j]) begin
            any = 1'b1;
            idx = W'(j);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          last_q <= W'(N - 1);
      else if (adv && any) last_q <= idx;
   end

   assign others = |(req & ~(N'(1) << last_q));

   AST_RR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && others) |-> (idx != last_q)); // R4

endmodule

// File: rtl/tx_sched.sv
module tx_sched
   import tx_sched_pkg::*;
#(
   parameter int NSRC   = 4,
   parameter int DATA_W = 256,
   parameter int LEN_W  = 10,
   parameter int TAG_W  = 10,
   parameter int RID_W  = 16,
   parameter int CR_W   = 12,
   parameter int ROB_W  = 10,
   localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NSRC-1:0]              src_hdr_valid,
   input  logic [NSRC-1:0][HDR_W-1:0]   src_hdr,
   input  logic [NSRC-1:0][1:0]         src_kind,
   input  logic [NSRC-1:0][LEN_W-1:0]   src_len,
   input  logic [NSRC-1:0][TAG_W-1:0]   src_tag,
   input  logic [NSRC-1:0][RID_W-1:0]   src_rid,
   output logic [NSRC-1:0]              src_hdr_ready,
   input  logic [NSRC-1:0]              src_pl_valid,
   input  logic [NSRC-1:0][DATA_W-1:0]  src_pl_data,
   output logic [NSRC-1:0]              src_pl_ready,
   input  logic [CR_W-1:0]              cr_ph,
   input  logic [CR_W-1:0]              cr_pd,
   input  logic [CR_W-1:0]              cr_nph,
   input  logic [CR_W-1:0]              cr_cplh,
   input  logic [CR_W-1:0]              cr_cpld,
   input  logic [ROB_W-1:0]             rob_free,
   output logic                         spend_valid,
   output logic [SRC_W-1:0]             spend_src,
   output logic [1:0]                   spend_kind,
   output logic [CR_W-1:0]              spend_dunits,
   output logic                         tx_valid,
   input  logic                         tx_ready,
   output logic [DATA_W-1:0]            tx_data,
   output logic                         tx_sop,
   output logic                         tx_last,
   output logic                         dc_valid,
   output logic [TAG_W-1:0]             dc_tag,
   output logic [RID_W-1:0]             dc_rid
);
   localparam int DPB     = DATA_W / 32;
   localparam int LOG_DPB = $clog2(DPB);
   localparam int BT_W    = LEN_W + 1;

   if (NSRC < 2) begin : g_bad_nsrc
      $error("tx_sched: NSRC must be at least 2");
   end
   if ((DATA_W % HDR_W) != 0 || (DPB & (DPB - 1)) != 0) begin : g_bad_dw
      $error("tx_sched: DATA_W must be a power-of-two multiple of 256");
   end

   // per-source eligibility
   logic [NSRC-1:0]           fits, pblk, req;
   logic [NSRC-1:0][CR_W-1:0] du;
   logic                      pblk_any;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      tx_sched_elig #(.LEN_W(LEN_W), .CR_W(CR_W), .ROB_W(ROB_W)) u_elig (
         .head_valid     (src_hdr_valid[i]),
         .kind           (tlp_kind_e'(src_kind[i])),
         .len            (src_len[i]),
         .cr_ph          (cr_ph),
         .cr_pd          (cr_pd),
         .cr_nph         (cr_nph),
         .cr_cplh        (cr_cplh),
         .cr_cpld        (cr_cpld),
         .rob_free       (rob_free),
         .fits           (fits[i]),
         .posted_blocked (pblk[i]),
         .dunits         (du[i])
      );
      assign req[i] = fits[i] &&
                      (kind_posted(tlp_kind_e'(src_kind[i])) || !pblk_any);
   end

   assign pblk_any = |pblk;

   // arbitration
   logic             busy_q, hdr_ph_q;
   logic             arb_any;
   logic [SRC_W-1:0] arb_idx;

   tx_sched_rr #(.N(NSRC)) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .adv   (!busy_q),
      .any   (arb_any),
      .idx   (arb_idx)
   );

   tlp_kind_e      sel_kind;
   logic [BT_W-1:0] sel_plb, sel_beats;

   assign sel_kind  = tlp_kind_e'(src_kind[arb_idx]);
   assign sel_plb   = ({1'b0, src_len[arb_idx]} + BT_W'(DPB - 1)) >> LOG_DPB;
   assign sel_beats = kind_carries_data(sel_kind) ? sel_plb + BT_W'(1) : BT_W'(1);

   assign spend_valid  = !busy_q && arb_any;
   assign spend_src    = arb_idx;
   assign spend_kind   = sel_kind;
   assign spend_dunits = du[arb_idx];

   // packet in flight
   logic [SRC_W-1:0] g_q;
   logic [BT_W-1:0]  beats_q;
   tlp_kind_e        g_kind_q;
   logic [TAG_W-1:0] g_tag_q;
   logic [RID_W-1:0] g_rid_q;
   logic             acc;

   assign tx_valid = busy_q && (hdr_ph_q || src_pl_valid[g_q]);
   assign tx_data  = hdr_ph_q ? DATA_W'(src_hdr[g_q]) : src_pl_data[g_q];
   assign tx_sop   = busy_q && hdr_ph_q;
   assign tx_last  = busy_q && (beats_q == BT_W'(1));
   assign acc      = tx_valid && tx_ready;

   for (genvar i = 0; i < NSRC; i++) begin : g_take
      assign src_hdr_ready[i] = acc && hdr_ph_q  && (g_q == SRC_W'(i));
      assign src_pl_ready[i]  = acc && !hdr_ph_q && (g_q == SRC_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         hdr_ph_q <= 1'b0;
         g_q      <= '0;
         beats_q  <= '0;
         g_kind_q <= TK_MWR;
         g_tag_q  <= '0;
         g_rid_q  <= '0;
         dc_valid <= 1'b0;
         dc_tag   <= '0;
         dc_rid   <= '0;
      end else begin
         dc_valid <= 1'b0;
         if (spend_valid) begin
            busy_q   <= 1'b1;
            hdr_ph_q <= 1'b1;
            g_q      <= arb_idx;
            beats_q  <= sel_beats;
            g_kind_q <= sel_kind;
            g_tag_q  <= src_tag[arb_idx];
            g_rid_q  <= src_rid[arb_idx];
         end else if (acc) begin
            hdr_ph_q <= 1'b0;
            beats_q  <= beats_q - BT_W'(1);
            if (tx_last) begin
               busy_q   <= 1'b0;
               dc_valid <= (g_kind_q == TK_MWR);
               dc_tag   <= g_tag_q;
               dc_rid   <= g_rid_q;
            end
         end
      end
   end

   // checks
   AST_POSTED_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
      (spend_valid && kind_posted(tlp_kind_e'(spend_kind)))
      |-> (cr_ph != '0 && cr_pd >= spend_dunits)); // R1

   AST_CPL_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
      (spend_valid && spend_kind == 2'(TK_CPL))
      |-> (cr_cplh != '0 && cr_cpld >= spend_dunits)); // R1

   AST_READ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (spend_valid && spend_kind == 2'(TK_MRD))
      |-> (cr_nph != '0 &&
           {{CR_W{1'b0}}, rob_free} >= {{ROB_W{1'b0}}, spend_dunits})); // R2

   AST_NO_PASS_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
      (spend_valid && !kind_posted(tlp_kind_e'(spend_kind))) |-> !pblk_any); // R3

   AST_HOLD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready)
      |=> (tx_valid && $stable(tx_sop) && $stable(tx_last) && $stable(g_q))); // R6

   AST_DUMMY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      dc_valid |-> $past(tx_valid && tx_ready && tx_last)); // R7

   AST_NO_GRANT_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_last) |=> !spend_valid); // R9

endmodule

// File: tb/tb_tx_sched.sv
`timescale 1ns/1ps
module tb_tx_sched;
   localparam int NS = 4;

   logic clk = 1'b0;
   logic rst_n;
   always #10 clk = ~clk;

   logic [NS-1:0]         src_hdr_valid, src_hdr_ready, src_pl_valid, src_pl_ready;
   logic [NS-1:0][255:0]  src_hdr, src_pl_data;
   logic [NS-1:0][1:0]    src_kind;
   logic [NS-1:0][9:0]    src_len, src_tag;
   logic [NS-1:0][15:0]   src_rid;
   logic [11:0]           cr_ph, cr_pd, cr_nph, cr_cplh, cr_cpld;
   logic [9:0]            rob_free;
   logic                  spend_valid, tx_valid, tx_ready, tx_sop, tx_last, dc_valid;
   logic [1:0]            spend_src, spend_kind;
   logic [11:0]           spend_dunits;
   logic [255:0]          tx_data;
   logic [9:0]            dc_tag;
   logic [15:0]           dc_rid;

   tx_sched dut (.*);

   typedef struct { logic [1:0] kind; int len; logic [9:0] tag; logic [15:0] rid; } pkt_t;
   typedef struct { logic [255:0] d; bit sop; bit last; } beat_t;

   pkt_t  srcq[NS][$];
   beat_t exp_q[$];
   int    grants[$];
   bit    hdr_done[NS], pl_up[NS];
   int    pl_idx[NS];
   int    ph, pd, nph, cplh, cpld, rob;
   bit    ready_rand, stall_en;
   bit    m_busy; int m_src, m_last; pkt_t m_pkt;
   bit    exp_dc; logic [9:0] exp_dtag; logic [15:0] exp_drid;
   bit    hold; logic [255:0] h_data; bit h_sop, h_last;
   int    checks, failures, dc_seen, cyc;

   function automatic logic [255:0] hdr_word(input logic [9:0] t);
      return {8{t, 6'h2A, 16'h5A00 ^ {6'd0, t}}};
   endfunction
   function automatic logic [255:0] pl_word(input logic [9:0] t, input int b);
      logic [5:0] bb = b[5:0];
      return {8{t, bb, 16'hC3A5}};
   endfunction
   function automatic int nbeats_pl(input pkt_t p);
      return (p.kind == 2'd1) ? 0 : (p.len + 7) / 8;
   endfunction
   function automatic int dus(input int len);
      return (len + 3) / 4;
   endfunction
   function automatic bit fits(input pkt_t p);
      case (p.kind)
         2'd0, 2'd3: return ph > 0 && pd >= dus(p.len);
         2'd1:       return nph > 0 && rob >= dus(p.len);
         default:    return cplh > 0 && cpld >= dus(p.len);
      endcase
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic push(input int s, input logic [1:0] k, input int len, input logic [9:0] t);
      pkt_t p;
      p.kind = k; p.len = len; p.tag = t; p.rid = 16'h1000 + 16'(t);
      srcq[s].push_back(p);
   endtask

   task automatic set_credits();
      ph = 8; pd = 64; nph = 8; cplh = 8; cpld = 64; rob = 64;
   endtask

   task automatic step();
      bit any, pb, exp_sv, exp_tv, acc; int sel;
      bit [NS-1:0] rq, ehr, epr;
      cyc++;
      if (cyc > 150000) begin
         chk(0, "R9", "watchdog expired", cyc, 150000);
         finish_run();
      end
      for (int i = 0; i < NS; i++) begin
         if (srcq[i].size() > 0) begin
            src_hdr_valid[i] = !hdr_done[i];
            src_hdr[i]  = hdr_word(srcq[i][0].tag);
            src_kind[i] = srcq[i][0].kind;
            src_len[i]  = 10'(srcq[i][0].len);
            src_tag[i]  = srcq[i][0].tag;
            src_rid[i]  = srcq[i][0].rid;
            if (hdr_done[i] && pl_idx[i] < nbeats_pl(srcq[i][0]) && !pl_up[i] &&
                (!stall_en || ($urandom % 4) != 0)) pl_up[i] = 1;
         end else begin
            src_hdr_valid[i] = 0; src_hdr[i] = '0; src_kind[i] = '0;
            src_len[i] = '0; src_tag[i] = '0; src_rid[i] = '0;
         end
         src_pl_valid[i] = pl_up[i];
         src_pl_data[i]  = pl_up[i] ? pl_word(srcq[i][0].tag, pl_idx[i]) : '0;
      end
      tx_ready = ready_rand ? (($urandom % 3) != 0) : 1'b1;
      cr_ph = 12'(ph); cr_pd = 12'(pd); cr_nph = 12'(nph);
      cr_cplh = 12'(cplh); cr_cpld = 12'(cpld); rob_free = 10'(rob);
      #1;
      // R7 dummy completion
      chk(dc_valid === exp_dc, "R7", "dc_valid", dc_valid, exp_dc);
      if (exp_dc) begin
         chk(dc_tag === exp_dtag, "R7", "dc_tag", dc_tag, exp_dtag);
         chk(dc_rid === exp_drid, "R7", "dc_rid", dc_rid, exp_drid);
      end
      if (dc_valid) dc_seen++;
      exp_dc = 0;
      // R6 hold
      if (hold)
         chk(tx_valid === 1 && tx_data === h_data && tx_sop === h_sop && tx_last === h_last,
             "R6", "held beat", tx_data, h_data);
      // grant prediction (R1 R2 R3 R4)
      pb = 0;
      for (int i = 0; i < NS; i++)
         if (srcq[i].size() > 0 && !hdr_done[i] && (srcq[i][0].kind == 0 || srcq[i][0].kind == 3)
             && !fits(srcq[i][0])) pb = 1;
      for (int i = 0; i < NS; i++)
         rq[i] = srcq[i].size() > 0 && !hdr_done[i] && fits(srcq[i][0]) &&
                 (srcq[i][0].kind == 0 || srcq[i][0].kind == 3 || !pb);
      any = 0; sel = 0;
      for (int k = 1; k <= NS; k++) begin
         int j = (m_last + k) % NS;
         if (!any && rq[j]) begin any = 1; sel = j; end
      end
      exp_sv = !m_busy && any;
      chk(spend_valid === exp_sv, "R3", "spend_valid", spend_valid, exp_sv);
      if (exp_sv && spend_valid) begin
         chk(spend_src === 2'(sel), "R4", "spend_src", spend_src, sel);
         chk(spend_dunits === 12'(dus(srcq[sel][0].len)), "R1", "spend_dunits",
             spend_dunits, dus(srcq[sel][0].len));
      end
      // beats (R5 R9)
      exp_tv = m_busy && exp_q.size() > 0 && (exp_q[0].sop || src_pl_valid[m_src]);
      chk(tx_valid === exp_tv, "R9", "tx_valid", tx_valid, exp_tv);
      if (tx_valid && exp_q.size() > 0) begin
         chk(tx_data === exp_q[0].d, "R5", "tx_data", tx_data, exp_q[0].d);
         chk(tx_sop === exp_q[0].sop && tx_last === exp_q[0].last, "R5", "sop/last",
             {tx_sop, tx_last}, {exp_q[0].sop, exp_q[0].last});
      end
      acc = tx_valid && tx_ready && exp_q.size() > 0;
      ehr = '0; epr = '0;
      if (acc) begin
         if (exp_q[0].sop) ehr[m_src] = 1; else epr[m_src] = 1;
      end
      chk(src_hdr_ready === ehr && src_pl_ready === epr, "R5", "source take",
          {src_hdr_ready, src_pl_ready}, {ehr, epr});
      hold = tx_valid && !tx_ready;
      h_data = tx_data; h_sop = tx_sop; h_last = tx_last;
      // model update
      if (acc) begin
         beat_t f = exp_q.pop_front();
         if (f.sop) hdr_done[m_src] = 1;
         else begin pl_idx[m_src]++; pl_up[m_src] = 0; end
         if (pl_idx[m_src] == nbeats_pl(srcq[m_src][0])) begin
            void'(srcq[m_src].pop_front());
            hdr_done[m_src] = 0; pl_idx[m_src] = 0;
         end
         if (f.last) begin
            m_busy = 0;
            if (m_pkt.kind == 2'd0) begin
               exp_dc = 1; exp_dtag = m_pkt.tag; exp_drid = m_pkt.rid;
            end
         end
      end
      if (exp_sv) begin
         beat_t b; int n;
         m_busy = 1; m_src = sel; m_last = sel; m_pkt = srcq[sel][0];
         grants.push_back(sel);
         n = nbeats_pl(m_pkt);
         b.d = hdr_word(m_pkt.tag); b.sop = 1; b.last = (n == 0); exp_q.push_back(b);
         for (int k = 0; k < n; k++) begin
            b.d = pl_word(m_pkt.tag, k); b.sop = 0; b.last = (k == n - 1); exp_q.push_back(b);
         end
         case (m_pkt.kind)
            2'd0, 2'd3: begin ph--; pd -= dus(m_pkt.len); end
            2'd1:       begin nph--; rob -= dus(m_pkt.len); end
            default:    begin cplh--; cpld -= dus(m_pkt.len); end
         endcase
      end
      @(negedge clk);
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic drain();
      int n = 0;
      while ((m_busy || srcq[0].size() + srcq[1].size() + srcq[2].size() + srcq[3].size() > 0)
             && n < 5000) begin
         step(); n++;
      end
      chk(n < 5000, "R9", "queues drained", n, 5000);
      run(2);
   endtask

   initial begin
      #(20 * 200000);
      chk(0, "R9", "watchdog timeout", 0, 1);
      finish_run();
   end

   initial begin
      int g0, wr;
      rst_n = 0; set_credits(); m_last = NS - 1; tx_ready = 0;
      src_hdr_valid = '0; src_pl_valid = '0; src_hdr = '0; src_pl_data = '0;
      src_kind = '0; src_len = '0; src_tag = '0; src_rid = '0;
      cr_ph = '0; cr_pd = '0; cr_nph = '0; cr_cplh = '0; cr_cpld = '0; rob_free = '0;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(tx_valid === 0, "R8", "tx_valid in reset", tx_valid, 0);
      chk(spend_valid === 0, "R8", "spend_valid in reset", spend_valid, 0);
      chk(dc_valid === 0, "R8", "dc_valid in reset", dc_valid, 0);
      rst_n = 1;
      @(negedge clk);

      // R4 round robin, source 0 first after reset (R8)
      push(0, 2'd0, 8, 10'd1); push(1, 2'd3, 1, 10'd2);
      push(2, 2'd2, 4, 10'd3); push(3, 2'd2, 12, 10'd4);
      drain();
      chk(grants.size() == 4, "R4", "grant count", grants.size(), 4);
      for (int i = 0; i < 4 && i < grants.size(); i++)
         chk(grants[i] == i, "R8", "first round order", grants[i], i);
      push(0, 2'd1, 16, 10'd5); push(1, 2'd3, 1, 10'd6); push(3, 2'd2, 0, 10'd7);
      drain();
      chk(grants.size() == 7 && grants[4] == 0 && grants[5] == 1 && grants[6] == 3,
          "R4", "wrap order skips idle", grants.size() > 6 ? grants[6] : -1, 3);

      // R5 R6 R7 R9 stalls, partial beats
      ready_rand = 1; stall_en = 1; set_credits(); dc_seen = 0; wr = 0;
      for (int r = 0; r < 6; r++) begin
         push(0, 2'd0, (r % 2) ? 17 : 9, 10'(40 + r)); wr++;
         push(2, 2'd2, 8 + r, 10'(60 + r));
         push(1, 2'd3, 1, 10'(80 + r));
         push(0, 2'd1, 32, 10'(90 + r));
         push(3, 2'd2, 64, 10'(100 + r));
         drain(); set_credits();
      end
      chk(dc_seen == wr, "R7", "dummy completions per write", dc_seen, wr);
      ready_rand = 0; stall_en = 0;

      // R3 posted block stops completions and reads
      set_credits(); pd = 0; g0 = grants.size();
      push(0, 2'd0, 8, 10'd20); push(2, 2'd2, 4, 10'd21); push(3, 2'd1, 4, 10'd22);
      run(20);
      chk(srcq[2].size() == 1 && srcq[3].size() == 1, "R3", "no pass of blocked write",
          srcq[2].size() + srcq[3].size(), 2);
      chk(grants.size() == g0, "R3", "no grant", grants.size(), g0);
      pd = 64; drain();

      // R2 read blocked by reorder room, completion bypasses (R3)
      set_credits(); rob = 0;
      push(0, 2'd1, 8, 10'd30); push(2, 2'd2, 8, 10'd31);
      run(20);
      chk(srcq[0].size() == 1, "R2", "read held without room", srcq[0].size(), 1);
      chk(srcq[2].size() == 0, "R3", "completion passes blocked read", srcq[2].size(), 0);
      rob = 2; run(10);
      chk(srcq[0].size() == 0, "R2", "read goes at exact room", srcq[0].size(), 0);
      drain();
      set_credits(); nph = 0; push(0, 2'd1, 4, 10'd32); run(10);
      chk(srcq[0].size() == 1, "R2", "read held without header credit", srcq[0].size(), 1);
      nph = 4; drain();

      // R1 credit boundary
      set_credits(); cpld = 2; push(3, 2'd2, 9, 10'd33); run(10);
      chk(srcq[3].size() == 1, "R1", "completion held one unit short", srcq[3].size(), 1);
      cpld = 3; drain();
      chk(cpld == 0 && grants[grants.size() - 1] == 3, "R1", "completion at exact credit",
          cpld, 0);
      set_credits(); ph = 0; push(1, 2'd3, 1, 10'd34); run(10);
      chk(srcq[1].size() == 1, "R1", "message held without header credit", srcq[1].size(), 1);
      ph = 4; drain();

      // R9 long write with other traffic arriving mid-packet
      set_credits(); ready_rand = 1;
      push(0, 2'd0, 64, 10'd50); run(3);
      push(2, 2'd2, 4, 10'd51); push(1, 2'd3, 1, 10'd52);
      drain();
      ready_rand = 0;

      finish_run();
   end
endmodule